// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recent page translations. Each slot holds a virtual page number, a physical frame number and a valid flag. A lookup is compared against every valid slot in the same cycle. On a hit, the frame number is returned on the next cycle and the page table walker is not used.

On a miss, the block stops accepting lookups and sends the page number to an external walker. The walker's answer is then written into a victim slot: the lowest-indexed free slot if one exists, and otherwise the slot chosen by a rotating pointer. The answer is also returned to the requester. A walker answer marked as a fault is passed through to the requester and installs nothing.

A flush input invalidates every slot in one cycle, for use on address-space switches. Two counters report accepted hits and accepted misses. Software can read these counts and compute the average access cost from the hit ratio.

Top module: `xlat_cache`

## Requirements
- R1: After reset, no slot is valid, resp_valid and walk_req_valid are low, req_ready is high, and both counters read zero.
- R2: An accepted lookup whose page is held in a valid slot raises resp_valid on the next cycle with that slot's frame number and resp_fault low, and it does not raise walk_req_valid.
- R3: An accepted lookup that misses raises walk_req_valid on the next cycle, with walk_req_vpn equal to the requested page. walk_req_vpn is held steady until walk_resp_valid is seen. req_ready stays low for that whole time.
- R4: A miss is answered with resp_valid one cycle after the cycle in which walk_resp_valid is high while walk_req_valid is high. The answer carries the walker's frame number and fault flag.
- R5: A mapping installed by a refill that did not fault hits on later lookups of the same page.
- R6: While any slot is invalid, a refill fills the lowest-indexed invalid slot, so no valid mapping is evicted. With 4 slots, four distinct pages can be held together.
- R7: Once every slot is valid, refills replace slots in rotation 0, 1, 2, 3, 0, and so on. The rotation starts at slot 0 and advances only when a valid slot is replaced.
- R8: A refill answered with walk_resp_fault high sets resp_fault and installs nothing, so the same page misses again.
- R9: A cycle with flush high invalidates every slot, and req_ready is low in that cycle. Pages that hit before the flush miss afterwards.
- R10: hit_count increments once for each accepted lookup that hits, and miss_count once for each accepted lookup that misses.
- R11: No two valid slots ever hold the same page number, so at most one slot matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all slots |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| resp_valid | output | 1 | Translation answer valid |
| resp_pfn | output | PFN_W | Physical frame number |
| resp_fault | output | 1 | Walker reported a fault |
| walk_req_valid | output | 1 | Refill request to the walker |
| walk_req_vpn | output | VPN_W | Page number to walk |
| walk_resp_valid | input | 1 | Walker answer valid |
| walk_resp_pfn | input | PFN_W | Walked frame number |
| walk_resp_fault | input | 1 | Walk found no mapping |
| hit_count | output | CNT_W | Accepted hits |
| miss_count | output | CNT_W | Accepted misses |

## Verification
The replacement order cannot be observed directly. It only shows when the cache is full and a later lookup hits or misses. The stimulus table therefore fills all four slots and confirms that every page is retained. It then interleaves misses with probes of pages that should or should not have survived, so that each step of the rotation, including the wrap back to slot 0, decides whether a probe hits. A fault refill is placed between rotations to show that it consumes no slot and does not advance the pointer.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 12,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             req_ready,
  output logic             resp_valid,
  output logic [PFN_W-1:0] resp_pfn,
  output logic             resp_fault,
  output logic             walk_req_valid,
  output logic [VPN_W-1:0] walk_req_vpn,
  input  logic             walk_resp_valid,
  input  logic [PFN_W-1:0] walk_resp_pfn,
  input  logic             walk_resp_fault,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   frm_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [PFN_W-1:0]   hit_pfn;
  logic [IDX_W-1:0]   free_idx, rr, victim;
  logic               has_free, busy, hit, accept, walk_done, install;
  logic [VPN_W-1:0]   pend_vpn;

  always_comb begin
    hit_pfn  = '0;
    free_idx = '0;
    has_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = vld[i] && (tag_q[i] == req_vpn);
      if (match[i]) hit_pfn = hit_pfn | frm_q[i];
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
  end

  assign hit       = |match;
  assign req_ready = !busy && !flush;
  assign accept    = req_valid && req_ready;
  assign walk_done = busy && walk_resp_valid;
  assign install   = walk_done && !walk_resp_fault && !flush;
  assign victim    = has_free ? free_idx : rr;

  assign walk_req_valid = busy;
  assign walk_req_vpn   = pend_vpn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pend_vpn   <= '0;
      resp_valid <= 1'b0;
      resp_pfn   <= '0;
      resp_fault <= 1'b0;
      hit_count  <= '0;
      miss_count <= '0;
      rr         <= '0;
    end else begin
      resp_valid <= (accept && hit) || walk_done;
      resp_fault <= walk_done && walk_resp_fault;
      if (walk_done)          resp_pfn <= walk_resp_pfn;
      else if (accept && hit) resp_pfn <= hit_pfn;
      if (accept && hit)  hit_count  <= hit_count + 1'b1;
      if (accept && !hit) begin
        miss_count <= miss_count + 1'b1;
        busy       <= 1'b1;
        pend_vpn   <= req_vpn;
      end else if (walk_done) begin
        busy <= 1'b0;
      end
      if (install && !has_free)
        rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld <= '0;
    end else if (install) begin
      vld[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      tag_q[victim] <= pend_vpn;
      frm_q[victim] <= walk_resp_pfn;
    end
  end

  // R11
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R3
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_resp_valid) |=> (walk_req_valid && $stable(walk_req_vpn) && !req_ready));

  // R2 R4
  resp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid && req_ready) || $past(walk_req_valid && walk_resp_valid)));

  // R8
  fault_noinstall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && walk_resp_valid && walk_resp_fault && !flush) |=> $stable(vld));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      ({1'b0, hit_count} + {1'b0, miss_count}) ==
      ($past({1'b0, hit_count}) + $past({1'b0, miss_count}) + 1'b1));
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 20;
  localparam int PW = 12;
  localparam int CW = 16;
  localparam int NVEC = 17;

  // {vpn, expect_hit, walk_fault, pfn}
  localparam logic [VW+PW+1:0] VEC [NVEC] = '{
    {20'h00010, 1'b0, 1'b0, 12'h101},  // R3 R4 first miss
    {20'h00010, 1'b1, 1'b0, 12'h101},  // R2 R5
    {20'h00020, 1'b0, 1'b0, 12'h202},
    {20'h00030, 1'b0, 1'b0, 12'h303},
    {20'h00040, 1'b0, 1'b0, 12'h404},  // now full
    {20'h00010, 1'b1, 1'b0, 12'h101},  // R6 retained
    {20'h00040, 1'b1, 1'b0, 12'h404},  // R6 retained
    {20'h00050, 1'b0, 1'b0, 12'h505},  // R7 evicts slot 0
    {20'h00020, 1'b1, 1'b0, 12'h202},
    {20'h00010, 1'b0, 1'b0, 12'h111},  // R7 evicts slot 1
    {20'h00030, 1'b1, 1'b0, 12'h303},
    {20'h00020, 1'b0, 1'b0, 12'h222},  // R7 evicts slot 2
    {20'h00050, 1'b1, 1'b0, 12'h505},
    {20'h00030, 1'b0, 1'b0, 12'h333},  // R7 evicts slot 3
    {20'h00060, 1'b0, 1'b1, 12'h000},  // R8 fault
    {20'h00060, 1'b0, 1'b0, 12'h606},  // R8 misses again, R7 wraps to slot 0
    {20'h00010, 1'b1, 1'b0, 12'h111}   // R7 slot 1 survived
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic req_valid = 1'b0;
  logic [VW-1:0] req_vpn = '0;
  logic req_ready, resp_valid, resp_fault, walk_req_valid;
  logic [PW-1:0] resp_pfn;
  logic [VW-1:0] walk_req_vpn;
  logic walk_resp_valid = 1'b0;
  logic [PW-1:0] walk_resp_pfn = '0;
  logic walk_resp_fault = 1'b0;
  logic [CW-1:0] hit_count, miss_count;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_cache uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_pfn(resp_pfn), .resp_fault(resp_fault),
    .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
    .walk_resp_valid(walk_resp_valid), .walk_resp_pfn(walk_resp_pfn),
    .walk_resp_fault(walk_resp_fault),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [VW-1:0] vpn, input bit exp_hit,
                        input bit wfault, input logic [PW-1:0] pfn, input string req);
    @(negedge clk);
    check({req, " ready"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_vpn   = vpn;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      check({req, " hit resp_valid"}, 32'(resp_valid), 32'd1);
      check({req, " hit pfn"}, 32'(resp_pfn), 32'(pfn));
      check({req, " hit no walk"}, 32'(walk_req_valid), 32'd0);
    end else begin
      check({req, " miss no resp"}, 32'(resp_valid), 32'd0);
      check({req, " walk_req"}, 32'(walk_req_valid), 32'd1);
      check({req, " walk vpn"}, 32'(walk_req_vpn), 32'(vpn));
      @(negedge clk);
      check("R3 walk held", 32'({walk_req_valid, req_ready}), 32'b10);
      check("R3 walk vpn held", 32'(walk_req_vpn), 32'(vpn));
      walk_resp_valid = 1'b1;
      walk_resp_pfn   = pfn;
      walk_resp_fault = wfault;
      @(negedge clk);
      walk_resp_valid = 1'b0;
      walk_resp_fault = 1'b0;
      check("R4 miss resp_valid", 32'(resp_valid), 32'd1);
      check("R4 miss resp_fault", 32'(resp_fault), 32'(wfault));
      if (!wfault) check("R4 miss pfn", 32'(resp_pfn), 32'(pfn));
      check("R4 walk dropped", 32'(walk_req_valid), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 resp_valid", 32'(resp_valid), 32'd0);
    check("R1 walk_req_valid", 32'(walk_req_valid), 32'd0);
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 hit_count", 32'(hit_count), 32'd0);
    check("R1 miss_count", 32'(miss_count), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      lookup(VEC[i][VW+PW+1:PW+2], VEC[i][PW+1], VEC[i][PW], VEC[i][PW-1:0], "R2/R3 table");
    end

    // R10
    check("R10 hit_count", 32'(hit_count), 32'd7);
    check("R10 miss_count", 32'(miss_count), 32'd10);

    // R9 flush
    @(negedge clk);
    flush = 1'b1;
    #1;
    check("R9 ready low in flush", 32'(req_ready), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    lookup(20'h00010, 1'b0, 1'b0, 12'h777, "R9 after flush");
    lookup(20'h00030, 1'b0, 1'b0, 12'h388, "R9 after flush");
    lookup(20'h00010, 1'b1, 1'b0, 12'h777, "R9 R5 refill hit");
    check("R10 hit_count end", 32'(hit_count), 32'd8);
    check("R10 miss_count end", 32'(miss_count), 32'd12);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule